// File: doc/BRIEF.md
# Handshake and Interrupt Flag Controller

This block holds the control-line and interrupt logic that sits beside two 8-bit parallel ports. Each port has one edge-sensitive input line (control line 1) and one configurable line (control line 2). Control line 2 can act as an edge-triggered interrupt input, a two-way handshake output, a one-cycle strobe after a data write, or a fixed level. A control register sets the mode of each line. The data and direction registers of the ports live elsewhere. This block sees only their access strobes, which arrive through the same small register window.

Seven interrupt sources feed a flag register:
- the four control lines,
- two timer events,
- one serial-complete event.

An enable register masks the flags. The masked flags combine into a summary bit and an active-low interrupt request. Software clears a flag by writing a 1 to it. Software sets or clears enable bits with a write where bit 7 selects the direction. All four control inputs pass through a synchroniser before edge detection.

The register window uses 3-bit addresses:
- 0: port B data (handshake access)
- 1: port A data (handshake access)
- 2: port A data without handshake
- 3: control register
- 4: flag register
- 5: enable register

Reads of addresses 0 to 2 return zero. A port access is any read or write to address 0 or 1. A port write is a write to address 0 or 1.

Top module: `hsk_irq_ctrl`

## Requirements
- R1: Control register bit 0 (port A) and bit 4 (port B) pick the control-line-1 interrupt edge: 0 selects falling and 1 selects rising. The event sets flag bit 1 (A) or bit 4 (B). An input change made just before a clock edge is visible in the flag register after the third rising clock edge (two synchroniser stages plus edge detection). The opposite edge sets nothing.
- R2: The control-line-2 mode field is bits 3:1 for port A and bits 7:5 for port B. Modes 000 and 001 set the line's flag on a falling edge. Modes 010 and 011 set it on a rising edge. The flag is bit 0 for port A and bit 3 for port B. In input modes the opposite edge sets nothing.
- R3: In modes 000 and 010, a handshake access (read or write) to the same port's data address clears that port's control-line-2 flag. In modes 001 and 011 the flag is kept. An access at address 2, or to the other port, never clears it.
- R4: Mode 100 drives the line. A port data write drives it low from the next clock. A selected-edge event on the same port's control line 1 drives it high again, at the same clock the line-1 flag sets. A port data read leaves the line unchanged.
- R5: In mode 101, a port data write drives the line low for exactly one clock cycle, after which it returns high. A port data read causes no strobe.
- R6: Mode 110 drives the line constantly low and mode 111 constantly high. In any mode with bit 2 = 0 the output enable is 0.
- R7: Timer-1, timer-2 and serial-done event inputs set flag bits 6, 5 and 2 respectively.
- R8: Writing the flag register clears every flag in bits 6:0 whose written bit is 1 and leaves the others. A set event in the same cycle as a clear wins.
- R9: Writing the enable register with bit 7 = 1 sets the enable bits written as 1. With bit 7 = 0 it clears them. The enable register reads with bit 7 = 1.
- R10: Flag register bit 7 reads 1 exactly when some flag is both set and enabled. The interrupt output is low exactly then.
- R11: After reset the control register, flags and enables are zero, the enable register reads 0x80, both control-line-2 outputs are high and undriven, and the interrupt output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register window address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; only its side effects at addresses 0 and 1 matter |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| ca1_in | input | 1 | Port A control line 1 |
| ca2_in | input | 1 | Port A control line 2 input |
| cb1_in | input | 1 | Port B control line 1 |
| cb2_in | input | 1 | Port B control line 2 input |
| t1_evt | input | 1 | Timer-1 event pulse |
| t2_evt | input | 1 | Timer-2 event pulse |
| ser_evt | input | 1 | Serial-complete event pulse |
| ca2_out | output | 1 | Port A control line 2 output level |
| ca2_oe | output | 1 | Port A control line 2 output enable |
| cb2_out | output | 1 | Port B control line 2 output level |
| cb2_oe | output | 1 | Port B control line 2 output enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume the following about the inputs:
- A register access presents a single address with one-cycle strobes.
- Event pulses and control-line changes are sampled only at clock edges.

The pulse and flag properties also assume the mode field stays steady around the access they judge. The bench therefore changes inputs only at the falling clock edge. It rewrites the control register only between scenarios, never in the cycle of a port write or a line transition.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

  typedef enum logic [2:0] {
    C2_IN_FALL_CLR  = 3'b000,
    C2_IN_FALL_KEEP = 3'b001,
    C2_IN_RISE_CLR  = 3'b010,
    C2_IN_RISE_KEEP = 3'b011,
    C2_OUT_HSK      = 3'b100,
    C2_OUT_PULSE    = 3'b101,
    C2_OUT_LOW      = 3'b110,
    C2_OUT_HIGH     = 3'b111
  } c2_mode_e;

  localparam int NFLAGS   = 7;
  localparam int FLAG_CA2 = 0;
  localparam int FLAG_CA1 = 1;
  localparam int FLAG_SER = 2;
  localparam int FLAG_CB2 = 3;
  localparam int FLAG_CB1 = 4;
  localparam int FLAG_T2  = 5;
  localparam int FLAG_T1  = 6;

  localparam int RA_PB    = 0;
  localparam int RA_PA    = 1;
  localparam int RA_PAQ   = 2;
  localparam int RA_PCR   = 3;
  localparam int RA_IFR   = 4;
  localparam int RA_IER   = 5;

  function automatic logic edge_hit(input logic rise, input logic fall, input logic sel_rising);
    return sel_rising ? rise : fall;
  endfunction

  function automatic logic c2_is_output(input c2_mode_e m);
    return m[2];
  endfunction

  function automatic logic c2_port_clears(input c2_mode_e m);
    return !m[2] && !m[0];
  endfunction

  function automatic logic [NFLAGS-1:0] ier_next(input logic [NFLAGS-1:0] old,
                                                 input logic [7:0] wd);
    return wd[7] ? (old | wd[NFLAGS-1:0]) : (old & ~wd[NFLAGS-1:0]);
  endfunction

  function automatic logic [NFLAGS-1:0] ifr_next(input logic [NFLAGS-1:0] old,
                                                 input logic [NFLAGS-1:0] setv,
                                                 input logic [NFLAGS-1:0] clrv);
    return (old & ~clrv) | setv;
  endfunction

endpackage

// File: rtl/hsk_sync_edge.sv
module hsk_sync_edge #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], din[g]};
        prev  <= chain[STAGES-1];
      end
    end

    assign rise[g] = chain[STAGES-1] & ~prev;
    assign fall[g] = ~chain[STAGES-1] & prev;
  end

endmodule

// File: rtl/hsk_ctl2_line.sv
module hsk_ctl2_line
  import hsk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  c2_mode_e mode,
  input  logic     ctl1_evt,
  input  logic     c2_rise,
  input  logic     c2_fall,
  input  logic     port_acc,
  input  logic     port_wr,
  output logic     flag_set,
  output logic     port_clr,
  output logic     line_out,
  output logic     line_oe
);

  logic hs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
    end else begin
      unique case (mode)
        C2_OUT_HSK: begin
          if (port_wr)       hs_q <= 1'b0;
          else if (ctl1_evt) hs_q <= 1'b1;
        end
        C2_OUT_PULSE: hs_q <= !port_wr;
        default:      hs_q <= 1'b1;
      endcase
    end
  end

  always_comb begin
    flag_set = !c2_is_output(mode) && edge_hit(c2_rise, c2_fall, mode[1]);
    port_clr = c2_port_clears(mode) && port_acc;
    line_oe  = c2_is_output(mode);
    unique case (mode)
      C2_OUT_LOW:   line_out = 1'b0;
      C2_OUT_HIGH:  line_out = 1'b1;
      C2_OUT_HSK,
      C2_OUT_PULSE: line_out = hs_q;
      default:      line_out = 1'b1;
    endcase
  end

endmodule

// File: rtl/hsk_flag_bank.sv
module hsk_flag_bank
  import hsk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] set_vec,
  input  logic [NFLAGS-1:0] clr_vec,
  input  logic              ier_wr,
  input  logic [7:0]        wdata,
  output logic [NFLAGS-1:0] ifr_q,
  output logic [NFLAGS-1:0] ier_q,
  output logic              summary
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifr_q <= '0;
      ier_q <= '0;
    end else begin
      ifr_q <= ifr_next(ifr_q, set_vec, clr_vec);
      if (ier_wr) ier_q <= ier_next(ier_q, wdata);
    end
  end

  assign summary = |(ifr_q & ier_q);

endmodule

// File: rtl/hsk_irq_ctrl.sv
module hsk_irq_ctrl
  import hsk_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              ca1_in,
  input  logic              ca2_in,
  input  logic              cb1_in,
  input  logic              cb2_in,
  input  logic              t1_evt,
  input  logic              t2_evt,
  input  logic              ser_evt,
  output logic              ca2_out,
  output logic              ca2_oe,
  output logic              cb2_out,
  output logic              cb2_oe,
  output logic              irq_n
);

  localparam int NPORTS = 2;
  localparam int NLINES = 2 * NPORTS;
  localparam logic [ADDR_W-1:0] A_PB  = ADDR_W'(RA_PB);
  localparam logic [ADDR_W-1:0] A_PA  = ADDR_W'(RA_PA);
  localparam logic [ADDR_W-1:0] A_PAQ = ADDR_W'(RA_PAQ);
  localparam logic [ADDR_W-1:0] A_PCR = ADDR_W'(RA_PCR);
  localparam logic [ADDR_W-1:0] A_IFR = ADDR_W'(RA_IFR);
  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(RA_IER);

  // access decode
  logic any_acc;
  logic pa_acc, pa_wr, pb_acc, pb_wr, pa_quiet;
  logic pcr_wr, ier_wr;
  logic [NFLAGS-1:0] ifr_wclr;

  assign any_acc  = wr_en | rd_en;
  assign pa_acc   = (addr == A_PA) & any_acc;
  assign pa_wr    = (addr == A_PA) & wr_en;
  assign pb_acc   = (addr == A_PB) & any_acc;
  assign pb_wr    = (addr == A_PB) & wr_en;
  assign pa_quiet = (addr == A_PAQ) & any_acc;
  assign pcr_wr   = (addr == A_PCR) & wr_en;
  assign ier_wr   = (addr == A_IER) & wr_en;
  assign ifr_wclr = ((addr == A_IFR) & wr_en) ? wdata[NFLAGS-1:0] : '0;

  // mode register
  logic [7:0] pcr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcr_q <= '0;
    else if (pcr_wr) pcr_q <= wdata;
  end

  // synchronised edges, line order {cb2, cb1, ca2, ca1}
  logic [NLINES-1:0] rise, fall;
  hsk_sync_edge #(.N(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cb2_in, cb1_in, ca2_in, ca1_in}),
    .rise (rise),
    .fall (fall)
  );

  // per-port control-line logic
  logic [NPORTS-1:0] c1_evt, c2_set, c2_clr, c2_out, c2_oe;
  logic [NPORTS-1:0] acc_v, wr_v;
  assign acc_v = {pb_acc, pa_acc};
  assign wr_v  = {pb_wr, pa_wr};

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign c1_evt[p] = edge_hit(rise[2*p], fall[2*p], pcr_q[4*p]);

    hsk_ctl2_line u_c2 (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (c2_mode_e'(pcr_q[4*p+3 -: 3])),
      .ctl1_evt(c1_evt[p]),
      .c2_rise (rise[2*p+1]),
      .c2_fall (fall[2*p+1]),
      .port_acc(acc_v[p]),
      .port_wr (wr_v[p]),
      .flag_set(c2_set[p]),
      .port_clr(c2_clr[p]),
      .line_out(c2_out[p]),
      .line_oe (c2_oe[p])
    );
  end

  // flag sources
  logic [NFLAGS-1:0] set_vec, clr_vec;
  always_comb begin
    set_vec           = '0;
    set_vec[FLAG_CA2] = c2_set[0];
    set_vec[FLAG_CA1] = c1_evt[0];
    set_vec[FLAG_SER] = ser_evt;
    set_vec[FLAG_CB2] = c2_set[1];
    set_vec[FLAG_CB1] = c1_evt[1];
    set_vec[FLAG_T2]  = t2_evt;
    set_vec[FLAG_T1]  = t1_evt;
    clr_vec           = ifr_wclr;
    clr_vec[FLAG_CA2] = ifr_wclr[FLAG_CA2] | c2_clr[0];
    clr_vec[FLAG_CB2] = ifr_wclr[FLAG_CB2] | c2_clr[1];
  end

  logic [NFLAGS-1:0] ifr_q, ier_q;
  logic              summary;
  hsk_flag_bank u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .ier_wr (ier_wr),
    .wdata  (wdata),
    .ifr_q  (ifr_q),
    .ier_q  (ier_q),
    .summary(summary)
  );

  // read mux
  always_comb begin
    if (addr == A_PCR)      rdata = pcr_q;
    else if (addr == A_IFR) rdata = {summary, ifr_q};
    else if (addr == A_IER) rdata = {1'b1, ier_q};
    else                    rdata = '0;
  end

  assign ca2_out = c2_out[0];
  assign ca2_oe  = c2_oe[0];
  assign cb2_out = c2_out[1];
  assign cb2_oe  = c2_oe[1];
  assign irq_n   = ~summary;

endmodule

// File: rtl/hsk_irq_chk.sv
module hsk_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] pcr,
  input logic [6:0] ifr,
  input logic [6:0] ier,
  input logic [6:0] set_vec,
  input logic [6:0] clr_vec,
  input logic       pa_wr,
  input logic       pb_wr,
  input logic       pa_quiet,
  input logic       ca2_out,
  input logic       ca2_oe,
  input logic       cb2_out,
  input logic       cb2_oe,
  input logic       irq_n
);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 7'd0) |=> ((ifr & $past(set_vec)) == $past(set_vec)));

  p_clear_takes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != 7'd0) |=> ((ifr & $past(clr_vec & ~set_vec)) == 7'd0));

  p_quiet_no_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pa_quiet |-> (clr_vec[0] == 1'b0 && clr_vec[3] == 1'b0));

  p_pulse_low_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pcr[3:1] == 3'b101 && pa_wr) |=> (pcr[3:1] != 3'b101 || !ca2_out));

  p_pulse_back_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pcr[3:1] == 3'b101 && !pa_wr) |=> (pcr[3:1] != 3'b101 || ca2_out));

  p_pulse_low_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pcr[7:5] == 3'b101 && pb_wr) |=> (pcr[7:5] != 3'b101 || !cb2_out));

  p_hsk_low_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pcr[3:1] == 3'b100 && pa_wr) |=> (pcr[3:1] != 3'b100 || !ca2_out));

  p_const_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pcr[3:2] == 2'b11) |-> (ca2_oe && ca2_out == pcr[1]));

  p_const_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pcr[7:6] == 2'b11) |-> (cb2_oe && cb2_out == pcr[5]));

  p_input_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcr[3] |-> !ca2_oe) and (!pcr[7] |-> !cb2_oe));

  p_irq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ifr & ier) == 0) |-> irq_n);

  p_irq_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ifr & ier) != 0) |-> !irq_n);

endmodule

bind hsk_irq_ctrl hsk_irq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pcr     (pcr_q),
  .ifr     (ifr_q),
  .ier     (ier_q),
  .set_vec (set_vec),
  .clr_vec (clr_vec),
  .pa_wr   (pa_wr),
  .pb_wr   (pb_wr),
  .pa_quiet(pa_quiet),
  .ca2_out (ca2_out),
  .ca2_oe  (ca2_oe),
  .cb2_out (cb2_out),
  .cb2_oe  (cb2_oe),
  .irq_n   (irq_n)
);

// File: tb/hsk_irq_ctrl_tb_top.sv
module hsk_irq_ctrl_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ca1_in = 1'b0, ca2_in = 1'b0, cb1_in = 1'b0, cb2_in = 1'b0;
  logic       t1_evt = 1'b0, t2_evt = 1'b0, ser_evt = 1'b0;
  logic       ca2_out, ca2_oe, cb2_out, cb2_oe, irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsk_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ca1_in(ca1_in), .ca2_in(ca2_in),
    .cb1_in(cb1_in), .cb2_in(cb2_in), .t1_evt(t1_evt), .t2_evt(t2_evt),
    .ser_evt(ser_evt), .ca2_out(ca2_out), .ca2_oe(ca2_oe), .cb2_out(cb2_out),
    .cb2_oe(cb2_oe), .irq_n(irq_n)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic port_op(logic [2:0] a, bit is_wr);
    addr = a; wdata = 8'h5A; wr_en = is_wr; rd_en = !is_wr;
    tick();
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic expect_ifr(string req, logic [7:0] exp);
    logic [7:0] v;
    reg_rd(3'd4, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    reg_rd(3'd3, v); check("R11 pcr", v, 8'h00);
    expect_ifr("R11 ifr", 8'h00);
    reg_rd(3'd5, v); check("R11 ier", v, 8'h80);
    check("R11 lines", {4'd0, ca2_out, ca2_oe, cb2_out, cb2_oe}, 8'b0000_1010);
    check("R11 irq_n", {7'd0, irq_n}, 8'd1);
  endtask

  task automatic t_ctl1();
    reg_wr(3'd3, 8'h00);
    ca1_in = 1'b1; tick(3);
    expect_ifr("R1 rising ignored", 8'h00);
    ca1_in = 1'b0; tick(2);
    expect_ifr("R1 before sync", 8'h00);
    tick();
    expect_ifr("R1 falling sets", 8'h02);
    reg_wr(3'd4, 8'h02);
    reg_wr(3'd3, 8'h01);
    ca1_in = 1'b1; tick(3);
    expect_ifr("R1 rising sets", 8'h02);
    reg_wr(3'd4, 8'h02);
    reg_wr(3'd3, 8'h10);
    cb1_in = 1'b1; tick(3);
    expect_ifr("R1 cb1 rising", 8'h10);
    reg_wr(3'd4, 8'h10);
    cb1_in = 1'b0; tick(3);
    expect_ifr("R1 cb1 falling ignored", 8'h00);
  endtask

  task automatic t_ctl2_in();
    reg_wr(3'd3, 8'h00);
    ca2_in = 1'b1; tick(3);
    expect_ifr("R2 mode000 rise ignored", 8'h00);
    ca2_in = 1'b0; tick(3);
    expect_ifr("R2 mode000 fall sets", 8'h01);
    port_op(3'd2, 1'b0); port_op(3'd2, 1'b1);
    expect_ifr("R3 quiet access keeps", 8'h01);
    port_op(3'd0, 1'b0);
    expect_ifr("R3 other port keeps", 8'h01);
    port_op(3'd1, 1'b0);
    expect_ifr("R3 mode000 read clears", 8'h00);
    reg_wr(3'd3, 8'h02);
    ca2_in = 1'b1; tick(3); ca2_in = 1'b0; tick(3);
    expect_ifr("R2 mode001 fall sets", 8'h01);
    port_op(3'd1, 1'b1);
    expect_ifr("R3 mode001 write keeps", 8'h01);
    reg_wr(3'd4, 8'h01);
    reg_wr(3'd3, 8'h04);
    ca2_in = 1'b1; tick(3);
    expect_ifr("R2 mode010 rise sets", 8'h01);
    port_op(3'd1, 1'b0);
    expect_ifr("R3 mode010 read clears", 8'h00);
    reg_wr(3'd3, 8'h06);
    ca2_in = 1'b0; tick(3);
    expect_ifr("R2 mode011 fall ignored", 8'h00);
    ca2_in = 1'b1; tick(3);
    port_op(3'd1, 1'b0);
    expect_ifr("R3 mode011 keeps", 8'h01);
    reg_wr(3'd4, 8'h01);
    reg_wr(3'd3, 8'h40);
    cb2_in = 1'b1; tick(3);
    expect_ifr("R2 cb2 rise sets", 8'h08);
    port_op(3'd1, 1'b0);
    expect_ifr("R3 port A keeps cb2", 8'h08);
    port_op(3'd0, 1'b0);
    expect_ifr("R3 port B clears cb2", 8'h00);
  endtask

  task automatic t_handshake();
    reg_wr(3'd3, 8'h08);
    check("R4 idle high", {6'd0, ca2_out, ca2_oe}, 8'b11);
    port_op(3'd1, 1'b1);
    check("R4 write low", {7'd0, ca2_out}, 8'd0);
    port_op(3'd1, 1'b0);
    check("R4 read no change", {7'd0, ca2_out}, 8'd0);
    ca1_in = 1'b0; tick(2);
    check("R4 still low", {7'd0, ca2_out}, 8'd0);
    tick();
    check("R4 ca1 edge high", {7'd0, ca2_out}, 8'd1);
    reg_wr(3'd4, 8'h7F);
    reg_wr(3'd3, 8'h90);
    port_op(3'd0, 1'b1);
    check("R4 cb2 write low", {7'd0, cb2_out}, 8'd0);
    cb1_in = 1'b1; tick(3);
    check("R4 cb1 edge high", {7'd0, cb2_out}, 8'd1);
    cb1_in = 1'b0; tick(3);
    reg_wr(3'd4, 8'h7F);
  endtask

  task automatic t_pulse();
    reg_wr(3'd3, 8'h0A);
    port_op(3'd1, 1'b1);
    check("R5 strobe low", {7'd0, ca2_out}, 8'd0);
    tick();
    check("R5 strobe over", {7'd0, ca2_out}, 8'd1);
    port_op(3'd1, 1'b0);
    check("R5 read no strobe", {7'd0, ca2_out}, 8'd1);
    reg_wr(3'd3, 8'hA0);
    port_op(3'd0, 1'b1);
    check("R5 cb2 strobe low", {7'd0, cb2_out}, 8'd0);
    tick();
    check("R5 cb2 strobe over", {7'd0, cb2_out}, 8'd1);
  endtask

  task automatic t_const();
    reg_wr(3'd3, 8'h0C);
    check("R6 ca2 low", {6'd0, ca2_out, ca2_oe}, 8'b01);
    reg_wr(3'd3, 8'h0E);
    check("R6 ca2 high", {6'd0, ca2_out, ca2_oe}, 8'b11);
    reg_wr(3'd3, 8'hC0);
    check("R6 cb2 low", {6'd0, cb2_out, cb2_oe}, 8'b01);
    reg_wr(3'd3, 8'hE0);
    check("R6 cb2 high", {6'd0, cb2_out, cb2_oe}, 8'b11);
    reg_wr(3'd3, 8'h00);
    check("R6 input undriven", {6'd0, ca2_oe, cb2_oe}, 8'b00);
    reg_wr(3'd4, 8'h7F);
  endtask

  task automatic t_events();
    t1_evt = 1'b1; tick(); t1_evt = 1'b0;
    expect_ifr("R7 timer1", 8'h40);
    t2_evt = 1'b1; tick(); t2_evt = 1'b0;
    expect_ifr("R7 timer2", 8'h60);
    ser_evt = 1'b1; tick(); ser_evt = 1'b0;
    expect_ifr("R7 serial", 8'h64);
    reg_wr(3'd4, 8'h64);
    expect_ifr("R8 clear all three", 8'h00);
  endtask

  task automatic t_ifr_clear();
    t1_evt = 1'b1; tick();
    addr = 3'd4; wdata = 8'h40; wr_en = 1'b1; tick();
    wr_en = 1'b0; t1_evt = 1'b0;
    expect_ifr("R8 set wins", 8'h40);
    t2_evt = 1'b1; tick(); t2_evt = 1'b0;
    reg_wr(3'd4, 8'h40);
    expect_ifr("R8 selective clear", 8'h20);
    reg_wr(3'd4, 8'h20);
    expect_ifr("R8 cleared", 8'h00);
  endtask

  task automatic t_ier();
    logic [7:0] v;
    reg_wr(3'd5, 8'h83); reg_rd(3'd5, v); check("R9 set bits", v, 8'h83);
    reg_wr(3'd5, 8'h01); reg_rd(3'd5, v); check("R9 clear bit", v, 8'h82);
    reg_wr(3'd5, 8'hFF); reg_rd(3'd5, v); check("R9 set all", v, 8'hFF);
    reg_wr(3'd5, 8'h7F); reg_rd(3'd5, v); check("R9 clear all", v, 8'h80);
  endtask

  task automatic t_irq();
    t2_evt = 1'b1; tick(); t2_evt = 1'b0;
    expect_ifr("R10 masked summary", 8'h20);
    check("R10 masked irq", {7'd0, irq_n}, 8'd1);
    reg_wr(3'd5, 8'hA0);
    expect_ifr("R10 enabled summary", 8'hA0);
    check("R10 irq low", {7'd0, irq_n}, 8'd0);
    reg_wr(3'd5, 8'h20);
    check("R10 disabled irq", {7'd0, irq_n}, 8'd1);
    reg_wr(3'd5, 8'hA0);
    reg_wr(3'd4, 8'h20);
    expect_ifr("R10 cleared summary", 8'h00);
    check("R10 irq released", {7'd0, irq_n}, 8'd1);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_ctl1();
    t_ctl2_in();
    t_handshake();
    t_pulse();
    t_const();
    t_events();
    t_ifr_clear();
    t_ier();
    t_irq();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule